// File: doc/BRIEF.md
# Parallel NOR Flash Identifier and Sector Address Streamer

This block probes a flash array built from two 16-bit NOR devices placed side by side on a 32-bit data bus. After a start pulse it acts as a bus master. It writes the three-step unlock and autoselect command sequence and reads the manufacturer code. If that code is one it knows, it also reads the device code. It then returns the array to read mode with a command word chosen by the detected device kind.

From the two codes it reports four results: a kind code, an identification flag, the sector count and the total size in bytes. The sector count is limited to a configured maximum.

Once the read-mode command has been accepted, the block streams the start byte address of every reported sector on a valid/ready output, together with its index. Two layouts are supported. The boot layout has a run of small sectors at the bottom followed by large ones. The uniform layout has only large sectors. A done pulse closes each probe, and the results stay on their pins until the next start.

The sector stream obeys standard valid/ready rules. A sector moves on a clock edge where both `sec_valid` and `sec_ready` are high. While `sec_valid` is high and `sec_ready` is low, the address and the index do not change and `sec_valid` stays high. The consumer may hold `sec_ready` low for any number of cycles, and the block waits.

Top module: `nor_probe_map`

## Requirements
- R1: After `start`, the first three bus writes are `0x00AA00AA` to byte address BASE_ADDR+0x1554, then `0x00550055` to BASE_ADDR+0xAA8, then `0x00900090` to BASE_ADDR+0x1554. The byte address is the word index shifted left by two.
- R2: The manufacturer code is read from BASE_ADDR+0. The device code is read from BASE_ADDR+4 only when the manufacturer code equals MFR_A or MFR_B. Otherwise exactly one read takes place.
- R3: `dev_type` is 0 for an unknown part, 1 for the boot layout and 2 for the uniform layout. `id_ok` is high exactly when `dev_type` is not 0.
- R4: A recognised manufacturer with device code DEV_BOOT reports 71 sectors (before the limit) and a size of 0x00800000.
- R5: A recognised manufacturer with device code DEV_UNIF reports 128 sectors (before the limit) and a size of 0x01000000.
- R6: An unknown manufacturer code, or an unknown device code, reports kind 0, sector count 0 and size 0, and streams no sector.
- R7: The last bus write of a probe goes to BASE_ADDR+0. Its data is `0x00F000F0` for the uniform kind and `0x00FF00FF` for the boot kind and for unknown parts.
- R8: The reported sector count is the smaller of the native count and MAX_SECT. Exactly that many sectors are streamed.
- R9: Sector i is streamed with index i, in increasing order, and starts at BASE_ADDR. In the boot layout, sectors 0 to 7 each span 0x4000 bytes and every later sector spans 0x20000 bytes. In the uniform layout, every sector spans 0x20000 bytes.
- R10: While `sec_valid` is high and `sec_ready` is low, `sec_valid`, `sec_addr` and `sec_index` stay unchanged on the next cycle.
- R11: The block never raises `bus_wr` and `bus_rd` together. A raised strobe keeps its address and write data until the cycle in which `bus_ack` is high. Read data is taken in that cycle.
- R12: `done` is a single-cycle pulse, given once per probe after the last sector transfer, or after the read-mode write when the count is 0. The results stay stable after it.
- R13: After reset, `done`, `id_ok`, `dev_type`, `sect_count`, `flash_size`, `sec_valid`, `bus_wr` and `bus_rd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a probe; sampled while idle |
| done | output | 1 | One-cycle pulse at the end of a probe |
| bus_addr | output | ADDR_W | Byte address of the current bus access |
| bus_wdata | output | 32 | Write data |
| bus_wr | output | 1 | Write strobe, held until acknowledged |
| bus_rd | output | 1 | Read strobe, held until acknowledged |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completes in this cycle |
| id_ok | output | 1 | Both codes recognised |
| dev_type | output | 2 | Kind code: 0 unknown, 1 boot, 2 uniform |
| sect_count | output | clog2(MAX_SECT+1) | Reported sector count after the limit |
| flash_size | output | 32 | Total array size in bytes |
| sec_valid | output | 1 | Sector entry is present |
| sec_ready | input | 1 | Consumer accepts the sector entry |
| sec_addr | output | ADDR_W | Start byte address of the sector |
| sec_index | output | clog2(MAX_SECT+1) | Index of the sector |

## Verification
The probe is run with four response patterns.

- A known manufacturer with the boot device separates the mixed-step address walk and the FF-style read-mode word.
- A second known manufacturer with the uniform device separates the fixed step and the F0-style word. With a bench limit below 128, this case also exercises the count limit.
- An unknown manufacturer shows that the device read is skipped.
- A known manufacturer with a foreign device code shows that two reads still occur but nothing is streamed.

The bus responder adds wait states in some runs, and the stream consumer stalls on alternate cycles in some runs. Together these separate correct holding of requests from an early advance.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_BOOT = 2'd1,
    KIND_UNIF = 2'd2
  } flash_kind_e;

  // command words, one 16-bit copy per device lane
  localparam logic [DATA_W-1:0] CMD_UNLOCK_A   = 32'h00AA_00AA;
  localparam logic [DATA_W-1:0] CMD_UNLOCK_B   = 32'h0055_0055;
  localparam logic [DATA_W-1:0] CMD_AUTOSEL    = 32'h0090_0090;
  localparam logic [DATA_W-1:0] CMD_READ_BOOT  = 32'h00FF_00FF;
  localparam logic [DATA_W-1:0] CMD_READ_UNIF  = 32'h00F0_00F0;

  // word indices of the unlock cycles; byte offset is index * 4
  localparam int WORD_UNLOCK_A = 'h555;
  localparam int WORD_UNLOCK_B = 'h2AA;
  localparam int WORD_MFR      = 0;
  localparam int WORD_DEV      = 1;

  // array geometry
  localparam int BOOT_SECTS  = 71;
  localparam int UNIF_SECTS  = 128;
  localparam int BOOT_SMALL  = 8;
  localparam logic [31:0] BOOT_BYTES = 32'h0080_0000;
  localparam logic [31:0] UNIF_BYTES = 32'h0100_0000;
  localparam logic [31:0] SMALL_STEP = 32'h0000_4000;
  localparam logic [31:0] LARGE_STEP = 32'h0002_0000;
endpackage

// File: rtl/id_classify.sv
module id_classify
  import nor_probe_pkg::*;
#(
  parameter logic [DATA_W-1:0] MFR_A    = 32'h0001_0001,
  parameter logic [DATA_W-1:0] MFR_B    = 32'h0004_0004,
  parameter logic [DATA_W-1:0] DEV_BOOT = 32'h22F9_22F9,
  parameter logic [DATA_W-1:0] DEV_UNIF = 32'h22D7_22D7
) (
  input  logic [DATA_W-1:0] mfr_code,
  input  logic [DATA_W-1:0] dev_code,
  output logic              mfr_ok,
  output flash_kind_e       kind
);
  always_comb begin
    mfr_ok = (mfr_code == MFR_A) || (mfr_code == MFR_B);
    if (!mfr_ok)                 kind = KIND_NONE;
    else if (dev_code == DEV_BOOT) kind = KIND_BOOT;
    else if (dev_code == DEV_UNIF) kind = KIND_UNIF;
    else                         kind = KIND_NONE;
  end
endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import nor_probe_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                MAX_SECT  = 128,
  parameter int                CNT_W     = $clog2(MAX_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic [DATA_W-1:0] mfr_q,
  output logic [DATA_W-1:0] dev_q,
  input  logic              mfr_ok,
  input  flash_kind_e       kind,
  output logic              map_go,
  input  logic              map_done,
  output logic              done,
  output logic              id_ok,
  output flash_kind_e       dev_type,
  output logic [CNT_W-1:0]  sect_count,
  output logic [31:0]       flash_size
);
  localparam int BOOT_N = (BOOT_SECTS > MAX_SECT) ? MAX_SECT : BOOT_SECTS;
  localparam int UNIF_N = (UNIF_SECTS > MAX_SECT) ? MAX_SECT : UNIF_SECTS;
  localparam logic [ADDR_W-1:0] OFS_A   = ADDR_W'(WORD_UNLOCK_A * 4);
  localparam logic [ADDR_W-1:0] OFS_B   = ADDR_W'(WORD_UNLOCK_B * 4);
  localparam logic [ADDR_W-1:0] OFS_MFR = ADDR_W'(WORD_MFR * 4);
  localparam logic [ADDR_W-1:0] OFS_DEV = ADDR_W'(WORD_DEV * 4);

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLK_A, ST_UNLK_B, ST_AUTOSEL, ST_RD_MFR,
    ST_CHK, ST_RD_DEV, ST_RESTORE, ST_MAP
  } seq_state_e;

  seq_state_e state;

  // bus request is a pure function of the state, so it holds until ack
  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = BASE_ADDR;
    bus_wdata = '0;
    unique case (state)
      ST_UNLK_A:  begin bus_wr = 1'b1; bus_addr = BASE_ADDR + OFS_A; bus_wdata = CMD_UNLOCK_A; end
      ST_UNLK_B:  begin bus_wr = 1'b1; bus_addr = BASE_ADDR + OFS_B; bus_wdata = CMD_UNLOCK_B; end
      ST_AUTOSEL: begin bus_wr = 1'b1; bus_addr = BASE_ADDR + OFS_A; bus_wdata = CMD_AUTOSEL; end
      ST_RD_MFR:  begin bus_rd = 1'b1; bus_addr = BASE_ADDR + OFS_MFR; end
      ST_RD_DEV:  begin bus_rd = 1'b1; bus_addr = BASE_ADDR + OFS_DEV; end
      ST_RESTORE: begin
        bus_wr    = 1'b1;
        bus_addr  = BASE_ADDR + OFS_MFR;
        bus_wdata = (kind == KIND_UNIF) ? CMD_READ_UNIF : CMD_READ_BOOT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mfr_q      <= '0;
      dev_q      <= '0;
      map_go     <= 1'b0;
      done       <= 1'b0;
      id_ok      <= 1'b0;
      dev_type   <= KIND_NONE;
      sect_count <= '0;
      flash_size <= '0;
    end else begin
      map_go <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mfr_q      <= '0;
          dev_q      <= '0;
          id_ok      <= 1'b0;
          dev_type   <= KIND_NONE;
          sect_count <= '0;
          flash_size <= '0;
          state      <= ST_UNLK_A;
        end
        ST_UNLK_A:  if (bus_ack) state <= ST_UNLK_B;
        ST_UNLK_B:  if (bus_ack) state <= ST_AUTOSEL;
        ST_AUTOSEL: if (bus_ack) state <= ST_RD_MFR;
        ST_RD_MFR:  if (bus_ack) begin
          mfr_q <= bus_rdata;
          state <= ST_CHK;
        end
        ST_CHK:     state <= mfr_ok ? ST_RD_DEV : ST_RESTORE;
        ST_RD_DEV:  if (bus_ack) begin
          dev_q <= bus_rdata;
          state <= ST_RESTORE;
        end
        ST_RESTORE: if (bus_ack) begin
          dev_type <= kind;
          id_ok    <= (kind != KIND_NONE);
          unique case (kind)
            KIND_BOOT: begin sect_count <= CNT_W'(BOOT_N); flash_size <= BOOT_BYTES; end
            KIND_UNIF: begin sect_count <= CNT_W'(UNIF_N); flash_size <= UNIF_BYTES; end
            default:   begin sect_count <= '0;             flash_size <= '0;         end
          endcase
          map_go <= 1'b1;
          state  <= ST_MAP;
        end
        ST_MAP: if (map_done) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_ack) |=>
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr) && $stable(bus_rd)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sect_count) <= 32'(MAX_SECT));

  // R2
  skip_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHK && !mfr_ok) |=> !bus_rd);
endmodule

// File: rtl/sect_stream.sv
module sect_stream
  import nor_probe_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              boot,
  input  logic [CNT_W-1:0]  total,
  output logic              sec_valid,
  input  logic              sec_ready,
  output logic [ADDR_W-1:0] sec_addr,
  output logic [CNT_W-1:0]  sec_index,
  output logic              fin
);
  logic             boot_q;
  logic [CNT_W-1:0] total_q;
  logic [31:0]      step;
  logic             last;

  always_comb begin
    step = (boot_q && (32'(sec_index) < 32'(BOOT_SMALL))) ? SMALL_STEP : LARGE_STEP;
    last = (sec_index == total_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_valid <= 1'b0;
      sec_addr  <= '0;
      sec_index <= '0;
      total_q   <= '0;
      boot_q    <= 1'b0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        sec_valid <= (total != '0);
        sec_addr  <= BASE_ADDR;
        sec_index <= '0;
        total_q   <= total;
        boot_q    <= boot;
        fin       <= (total == '0);
      end else if (sec_valid && sec_ready) begin
        if (last) begin
          sec_valid <= 1'b0;
          fin       <= 1'b1;
        end else begin
          sec_index <= sec_index + CNT_W'(1);
          sec_addr  <= sec_addr + ADDR_W'(step);
        end
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && !sec_ready) |=>
      (sec_valid && $stable(sec_addr) && $stable(sec_index)));

  // R8
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |-> (sec_index < total_q));
endmodule

// File: rtl/nor_probe_map.sv
module nor_probe_map
  import nor_probe_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int                MAX_SECT  = 128,
  parameter logic [31:0]       MFR_A     = 32'h0001_0001,
  parameter logic [31:0]       MFR_B     = 32'h0004_0004,
  parameter logic [31:0]       DEV_BOOT  = 32'h22F9_22F9,
  parameter logic [31:0]       DEV_UNIF  = 32'h22D7_22D7,
  localparam int               CNT_W     = $clog2(MAX_SECT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic              id_ok,
  output logic [1:0]        dev_type,
  output logic [CNT_W-1:0]  sect_count,
  output logic [31:0]       flash_size,
  output logic              sec_valid,
  input  logic              sec_ready,
  output logic [ADDR_W-1:0] sec_addr,
  output logic [CNT_W-1:0]  sec_index
);
  logic [DATA_W-1:0] mfr_q, dev_q;
  logic              mfr_ok;
  flash_kind_e       kind, type_q;
  logic              map_go, map_done;

  id_classify #(
    .MFR_A(MFR_A), .MFR_B(MFR_B), .DEV_BOOT(DEV_BOOT), .DEV_UNIF(DEV_UNIF)
  ) u_class (
    .mfr_code(mfr_q), .dev_code(dev_q), .mfr_ok(mfr_ok), .kind(kind)
  );

  probe_seq #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .MAX_SECT(MAX_SECT), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .mfr_q(mfr_q), .dev_q(dev_q), .mfr_ok(mfr_ok), .kind(kind),
    .map_go(map_go), .map_done(map_done), .done(done),
    .id_ok(id_ok), .dev_type(type_q), .sect_count(sect_count), .flash_size(flash_size)
  );

  sect_stream #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)
  ) u_stream (
    .clk(clk), .rst_n(rst_n), .go(map_go), .boot(type_q == KIND_BOOT),
    .total(sect_count), .sec_valid(sec_valid), .sec_ready(sec_ready),
    .sec_addr(sec_addr), .sec_index(sec_index), .fin(map_done)
  );

  assign dev_type = type_q;

  // R3
  id_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_ok == (dev_type != 2'd0));

  // R6
  no_stream_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_type == 2'd0) |-> !sec_valid);
endmodule

// File: tb/test_nor_probe_map.sv
module test_nor_probe_map;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam int          MAXS = 100;
  localparam int          CW   = $clog2(MAXS + 1);
  localparam logic [31:0] MA = 32'h0001_0001, MB = 32'h0004_0004;
  localparam logic [31:0] DB = 32'h22F9_22F9, DU = 32'h22D7_22D7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, bus_wr, bus_rd, id_ok, sec_valid;
  logic [31:0] bus_addr, bus_wdata, flash_size, sec_addr;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0, sec_ready = 1'b0;
  logic [1:0] dev_type;
  logic [CW-1:0] sect_count, sec_index;

  always #5 clk = ~clk;

  nor_probe_map #(.ADDR_W(32), .BASE_ADDR(BASE), .MAX_SECT(MAXS),
    .MFR_A(MA), .MFR_B(MB), .DEV_BOOT(DB), .DEV_UNIF(DU)) i_nor_probe_map (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .id_ok(id_ok), .dev_type(dev_type),
    .sect_count(sect_count), .flash_size(flash_size), .sec_valid(sec_valid),
    .sec_ready(sec_ready), .sec_addr(sec_addr), .sec_index(sec_index));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bus responder state
  logic [31:0] mfr_resp, dev_resp;
  int lat = 0, wait_cnt = 0, bus_err = 0;
  bit pend = 0;
  logic [31:0] pend_addr, pend_data;
  logic [31:0] wr_a[8], wr_d[8], rd_a[8];
  int n_wr = 0, n_rd = 0;

  // stream consumer state
  int rmode = 0, cyc = 0, n_sec = 0, stall_err = 0, order_err = 0, n_stall = 0;
  bit held = 0;
  logic [31:0] held_addr;
  logic [CW-1:0] held_idx;
  logic [31:0] got_addr[128];

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  initial begin : responder
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        pend = 0;
      end else if (bus_wr || bus_rd) begin
        if (bus_wr && bus_rd) bus_err++;
        if (pend && (bus_addr != pend_addr || bus_wdata != pend_data)) bus_err++;
        pend = 1; pend_addr = bus_addr; pend_data = bus_wdata;
        if (wait_cnt >= lat) begin
          wait_cnt = 0;
          bus_ack = 1'b1;
          if (bus_wr) begin
            if (n_wr < 8) begin wr_a[n_wr] = bus_addr; wr_d[n_wr] = bus_wdata; end
            n_wr++;
          end else begin
            if (n_rd < 8) rd_a[n_rd] = bus_addr;
            n_rd++;
            bus_rdata = (bus_addr == BASE) ? mfr_resp :
                        (bus_addr == BASE + 4) ? dev_resp : 32'hDEAD_BEEF;
          end
        end else wait_cnt++;
      end
    end
  end

  initial begin : consumer
    forever begin
      @(negedge clk);
      cyc++;
      sec_ready = (rmode == 0) ? 1'b1 : cyc[0];
      if (held) begin
        if (!sec_valid || sec_addr != held_addr || sec_index != held_idx) stall_err++;
      end
      held = sec_valid && !sec_ready;
      if (held) begin held_addr = sec_addr; held_idx = sec_index; n_stall++; end
      if (sec_valid && sec_ready) begin
        if (32'(sec_index) != n_sec) order_err++;
        if (n_sec < 128) got_addr[n_sec] = sec_addr;
        n_sec++;
      end
    end
  end

  function automatic logic [31:0] exp_addr(input bit boot, input int i);
    if (boot) return (i < 8) ? BASE + 32'(i) * 32'h4000 : BASE + 32'(i - 7) * 32'h20000;
    return BASE + 32'(i) * 32'h20000;
  endfunction

  // runs one probe, waits for done, checks everything common
  task automatic run_probe(input logic [31:0] mresp, input logic [31:0] dresp,
                           input int l, input int rm, input logic [1:0] e_type,
                           input int e_cnt, input logic [31:0] e_size,
                           input int e_rd, input logic [31:0] e_restore, input string tag);
    int tmo;
    mfr_resp = mresp; dev_resp = dresp; lat = l; rmode = rm;
    n_wr = 0; n_rd = 0; n_sec = 0; bus_err = 0; stall_err = 0; order_err = 0; n_stall = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    tmo = 0;
    while (!done && tmo < 5000) begin @(negedge clk); tmo++; end
    chk(done === 1'b1, {tag, " R12 done seen"}, 32'(done), 1);
    chk(n_wr == 4, {tag, " R1 R7 write count"}, n_wr, 4);
    chk(wr_a[0] == BASE + 32'h1554 && wr_d[0] == 32'h00AA00AA, {tag, " R1 first unlock"}, wr_d[0], 32'h00AA00AA);
    chk(wr_a[1] == BASE + 32'hAA8 && wr_d[1] == 32'h00550055, {tag, " R1 second unlock"}, wr_a[1], BASE + 32'hAA8);
    chk(wr_a[2] == BASE + 32'h1554 && wr_d[2] == 32'h00900090, {tag, " R1 autoselect"}, wr_d[2], 32'h00900090);
    chk(wr_a[3] == BASE && wr_d[3] == e_restore, {tag, " R7 read-mode word"}, wr_d[3], e_restore);
    chk(n_rd == e_rd, {tag, " R2 read count"}, n_rd, e_rd);
    chk(rd_a[0] == BASE, {tag, " R2 manufacturer address"}, rd_a[0], BASE);
    if (e_rd == 2) chk(rd_a[1] == BASE + 4, {tag, " R2 device address"}, rd_a[1], BASE + 4);
    chk(bus_err == 0, {tag, " R11 bus strobe rules"}, bus_err, 0);
    chk(dev_type == e_type, {tag, " R3 kind code"}, 32'(dev_type), 32'(e_type));
    chk(id_ok == (e_type != 0), {tag, " R3 id flag"}, 32'(id_ok), 32'(e_type != 0));
    chk(32'(sect_count) == e_cnt, {tag, " R4 R5 R6 R8 sector count"}, 32'(sect_count), e_cnt);
    chk(flash_size == e_size, {tag, " R4 R5 R6 size"}, flash_size, e_size);
    chk(n_sec == e_cnt, {tag, " R8 streamed count"}, n_sec, e_cnt);
    chk(order_err == 0, {tag, " R9 index order"}, order_err, 0);
    begin
      int bad_i = -1;
      for (int i = 0; i < e_cnt && i < 128; i++)
        if (bad_i < 0 && got_addr[i] != exp_addr(e_type == 2'd1, i)) bad_i = i;
      chk(bad_i < 0, {tag, " R9 sector addresses"},
          (bad_i < 0) ? 32'h0 : got_addr[bad_i], (bad_i < 0) ? 32'h0 : exp_addr(e_type == 2'd1, bad_i));
    end
    chk(stall_err == 0, {tag, " R10 hold under stall"}, stall_err, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R12 done single cycle"}, 32'(done), 0);
    repeat (3) @(negedge clk);
    chk(dev_type == e_type && flash_size == e_size && !sec_valid, {tag, " R12 results held"},
        flash_size, e_size);
  endtask

  task automatic t_reset;
    chk(!done && !id_ok && dev_type == 0 && sect_count == 0, "R13 reset results", 32'(dev_type), 0);
    chk(flash_size == 0 && !sec_valid && !bus_wr && !bus_rd, "R13 reset strobes", flash_size, 0);
  endtask

  task automatic t_boot;
    run_probe(MA, DB, 0, 0, 2'd1, 71, 32'h0080_0000, 2, 32'h00FF00FF, "boot R4");
  endtask

  task automatic t_uniform;
    run_probe(MB, DU, 2, 1, 2'd2, 100, 32'h0100_0000, 2, 32'h00F000F0, "uniform R5 R8");
    chk(n_stall > 0, "R10 stalls exercised", n_stall, 1);
  endtask

  task automatic t_boot_stalled;
    run_probe(MB, DB, 1, 1, 2'd1, 71, 32'h0080_0000, 2, 32'h00FF00FF, "boot stalled R9 R10");
  endtask

  task automatic t_bad_mfr;
    run_probe(32'h0089_0089, DU, 1, 0, 2'd0, 0, 32'h0, 1, 32'h00FF00FF, "bad mfr R6");
  endtask

  task automatic t_bad_dev;
    run_probe(MA, 32'h1234_1234, 0, 0, 2'd0, 0, 32'h0, 2, 32'h00FF00FF, "bad dev R6");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp=0", 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_boot();
    t_uniform();
    t_bad_mfr();
    t_bad_dev();
    t_boot_stalled();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule